// File: doc/BRIEF.md
# Grouped Lookahead Binary Adder

This block adds two unsigned binary operands of parameterised width (30 bits by default) together with a single forced carry input. It returns the sum and the carry out of the most significant stage. The block has no clock and no state: it is pure combinational logic.

Each bit position produces a generate term (both operand bits set) and a propagate term (the operand bits differ). The bit positions are split into fixed groups, three bits wide by default. Inside a group, every carry is formed at once as a flat sum of products. Each product is built from that group's generate and propagate terms and from the carry entering the group. The carry leaving a group then feeds the next group in a chain. When the width is not a multiple of the group size, the top group is shorter and uses the same flat form cut to its length.

Top module: `cla_group_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + carry_force_i`, with all three taken as unsigned numbers.
- R2: `carry_out_o` equals bit WIDTH of `a_i + b_i + carry_force_i`, which is the carry leaving the most significant stage.
- R3: With both operands zero, `sum_o` equals `carry_force_i` in bit 0 and zeros elsewhere, and `carry_out_o` is 0.
- R4: With both operands all ones, `sum_o` is all ones when `carry_force_i` is 1 and all ones except bit 0 when it is 0; `carry_out_o` is 1 in both cases.
- R5: A carry entering a run of propagate positions (operand bits that differ) passes across every group boundary in the run. For example, all-ones plus zero plus a forced carry gives a zero sum and `carry_out_o` = 1.
- R6: The carry into each stage equals generate OR (propagate AND carry into the stage below), even though each carry is formed non-recursively inside its group.
- R7: When WIDTH is not a multiple of the group size, R1 and R2 still hold; the top group covers only the remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| carry_force_i | input | 1 | Carry forced into stage 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_out_o | output | 1 | Carry out of the top stage (overflow carry) |

## Verification
The case that is hardest to reach from the ports is a carry that starts at the bottom and crosses every group boundary. It needs a propagate at every bit position, and random operands almost never produce one. Directed stimulus covers it: all-ones against zero with the forced carry set, and complementary alternating patterns, which propagate at every bit. Other operands place a single generate on the top bit of one group followed by propagates above it, so that the carry has to cross exactly that boundary. A second instance with a width of 8 runs the same patterns on a shortened top group.

// File: rtl/cla_group_adder.sv
module cla_group_adder #(
  parameter int WIDTH = 30,
  parameter int GROUP = 3
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_force_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out_o
);
  localparam int NGROUPS = (WIDTH + GROUP - 1) / GROUP;

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH:0]   car;
  logic             grp_cin;
  logic             acc;
  logic             chain;
  logic [WIDTH:0]   total;

  always_comb begin
    gen     = a_i & b_i;
    prop    = a_i ^ b_i;
    car     = '0;
    car[0]  = carry_force_i;
    grp_cin = carry_force_i;
    acc     = 1'b0;
    chain   = 1'b0;
    for (int gi = 0; gi < NGROUPS; gi++) begin
      for (int j = 0; j < GROUP; j++) begin
        if (gi * GROUP + j < WIDTH) begin
          acc = 1'b0;
          for (int k = gi * GROUP; k <= gi * GROUP + j; k++) begin
            chain = gen[k];
            for (int m = k + 1; m <= gi * GROUP + j; m++)
              chain = chain & prop[m];
            acc = acc | chain;
          end
          chain = grp_cin;
          for (int m = gi * GROUP; m <= gi * GROUP + j; m++)
            chain = chain & prop[m];
          car[gi * GROUP + j + 1] = acc | chain;
        end
      end
      if ((gi + 1) * GROUP < WIDTH)
        grp_cin = car[(gi + 1) * GROUP];
      else
        grp_cin = car[WIDTH];
    end
    sum_o       = prop ^ car[WIDTH-1:0];
    carry_out_o = car[WIDTH];
    total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_force_i};

    if (!$isunknown({a_i, b_i, carry_force_i})) begin
      for (int i = 0; i < WIDTH; i++) begin
        // R6: flat in-group lookahead agrees with the recursive carry rule
        a_r6_carry_recurrence: assert (car[i+1] == (gen[i] | (prop[i] & car[i])))
          else $error("carry recurrence broken at stage %0d", i);
      end
      // R1: sum bits match the arithmetic total
      a_r1_sum_value: assert (sum_o == total[WIDTH-1:0])
        else $error("sum mismatch");
      // R2: top carry matches the arithmetic total
      a_r2_carry_out: assert (carry_out_o == total[WIDTH])
        else $error("carry out mismatch");
      // R3: zero operands pass only the forced carry
      a_r3_zero_operands: assert (!((a_i == '0) && (b_i == '0)) ||
                                  (!carry_out_o && (sum_o == {{(WIDTH-1){1'b0}}, carry_force_i})))
        else $error("zero operand result wrong");
      // R5: a full propagate chain delivers the forced carry to the top
      a_r5_full_propagate: assert (!(&prop) || (carry_out_o == carry_force_i))
        else $error("full propagate chain lost carry");
    end
  end
endmodule

// File: tb/cla_group_adder_bench.sv
module cla_group_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 30;
  localparam int W8 = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          cf, co;
  logic [W8-1:0] a8, b8, s8;
  logic          cf8, co8;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cla_group_adder #(.WIDTH(W), .GROUP(3)) u_cla_group_adder (
    .a_i(a), .b_i(b), .carry_force_i(cf), .sum_o(s), .carry_out_o(co));

  cla_group_adder #(.WIDTH(W8), .GROUP(3)) u_cla_group_adder_w8 (
    .a_i(a8), .b_i(b8), .carry_force_i(cf8), .sum_o(s8), .carry_out_o(co8));

  function automatic logic [W:0] ref30(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W8:0] ref8(logic [W8-1:0] x, logic [W8-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W8{1'b0}}, c};
  endfunction

  task automatic run30(string tag, logic [W-1:0] x, logic [W-1:0] y, logic c);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cf = c;
    #1;
    exp = ref30(x, y, c);
    checks++;
    if ({co, s} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cf=%b got {co,sum}=%h expected %h", tag, x, y, c, {co, s}, exp);
    end
  endtask

  task automatic run8(string tag, logic [W8-1:0] x, logic [W8-1:0] y, logic c);
    logic [W8:0] exp;
    @(negedge clk);
    a8 = x; b8 = y; cf8 = c;
    #1;
    exp = ref8(x, y, c);
    checks++;
    if ({co8, s8} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cf=%b got {co,sum}=%h expected %h", tag, x, y, c, {co8, s8}, exp);
    end
  endtask

  initial begin
    logic [W-1:0] ones;
    ones = '1;
    a = '0; b = '0; cf = 1'b0;
    a8 = '0; b8 = '0; cf8 = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if ({co, s} !== '0) begin
      errors++;
      $display("FAIL R3 idle: got %h expected 0", {co, s});
    end
    run30("R3 zero no carry", '0, '0, 1'b0);
    run30("R3 zero forced carry", '0, '0, 1'b1);
    run30("R4 all ones with carry", ones, ones, 1'b1);
    run30("R4 all ones without carry", ones, ones, 1'b0);
    run30("R5 ones plus zero carry in", ones, '0, 1'b1);
    run30("R5 alternating A", 30'h2AAA_AAAA, 30'h1555_5555, 1'b1);
    run30("R5 alternating B", 30'h1555_5555, 30'h2AAA_AAAA, 1'b0);
    run30("R1 alternating same", 30'h2AAA_AAAA, 30'h2AAA_AAAA, 1'b1);
    for (int g = 0; g < 10; g++) begin
      logic [W-1:0] x, y;
      x = ones << (g * 3 + 2);
      y = {{(W-1){1'b0}}, 1'b1} << (g * 3 + 2);
      run30("R6 generate at group top", x, y, 1'b0);
      run30("R5 boundary crossing", ones >> (g * 3), {{(W-1){1'b0}}, 1'b1}, 1'b0);
    end
    run30("R2 top carry only", 30'h2000_0000, 30'h2000_0000, 1'b0);
    void'($urandom(32'd4711));
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] x, y;
      x = W'($urandom());
      y = W'($urandom());
      run30("R1 R2 random", x, y, 1'($urandom()));
    end
    run8("R7 short group ones", 8'hFF, 8'h00, 1'b1);
    run8("R7 short group all ones", 8'hFF, 8'hFF, 1'b1);
    run8("R7 short group alternating", 8'hAA, 8'h55, 1'b1);
    run8("R7 carry into short group", 8'h3F, 8'h01, 1'b0);
    for (int n = 0; n < 200; n++)
      run8("R7 random", 8'($urandom()), 8'($urandom()), 1'($urandom()));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule